// File: doc/BRIEF.md
# Character-Cell On-Screen Display Generator

This block lays a text window over a video raster. It counts pixels from the horizontal sync and lines from the vertical sync. Inside a window of 6 rows by 20 columns of 12 x 15 pixel cells, it reads the character code of the current cell from an internal video RAM. It then fetches the current glyph line from a character ROM of 6-bit words, one half of the line at a time. It serialises the selected bit and chooses the output colour from an attribute byte that belongs to the whole row.

A host loads the video RAM through a simple synchronous write port. It sets the window origin and the pixel height through static register inputs. The red, green and blue outputs and the blank (overlay-enable) output are registered. They are meant to switch an external video mixer between the host picture and the overlay.

Top module: `osd_gen`

## Requirements
- R1: While reset is asserted and after it is released, red, green, blue and blank stay 0 until the window is first drawn.
- R2: hSync high at a clock edge restarts the pixel counter at 0. Window pixel x (0..239) appears on the outputs when the count since that edge equals horzPos+1+x. The outputs are dark at every other count.
- R3: vSync high at a clock edge restarts the line count at 0, even when hSync is high in the same cycle. A vSync on its own restarts only the line count and leaves the pixel counter running. Each hSync without vSync adds one line. The window's first line is line vertPos.
- R4: The window is 20 cells of 12 pixels across and 6 rows of 15 glyph lines down. A cell covers window pixels 12*col..12*col+11.
- R5: pixSize values 0, 1, 2 and 3 make each glyph line span 1, 2, 3 or 4 raster lines. The window is therefore 90*(pixSize+1) lines tall.
- R6: A write to the video RAM uses ramAddr[7:5] as the row (0..5) and ramAddr[4:0] as the offset. Offset 0 holds the row attribute, and offsets 1..20 hold the codes for columns 0..19. Writes to rows 6 and 7 or to offsets 21..31 are ignored.
- R7: The glyph word address is code*30 + glyphLine*2 + half. Half 0 covers pixels 0..5 of the cell and half 1 covers pixels 6..11. Within a word, bit 5 is the leftmost pixel.
- R8: The built-in test ROM returns word = addr[5:0] XOR addr[11:6]. Codes 96..127 draw no foreground pixels.
- R9: In the row attribute, bits [2:0] are the character colour (bit 2 red, bit 1 green, bit 0 blue). Bit 3 enables the background, and bits [6:4] are the background colour in the same red, green, blue order.
- R10: A foreground pixel shows the character colour. Any other window pixel shows the background colour if the background is enabled, and black otherwise. Outside the window the colour is black.
- R11: blank is high exactly for foreground pixels and for window pixels of a row whose background is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSync | input | 1 | Horizontal sync pulse, one clock wide |
| vSync | input | 1 | Vertical sync pulse, one clock wide |
| vertPos | input | 8 | Line number of the window's first line |
| horzPos | input | 8 | Pixel count at which the window starts |
| pixSize | input | 2 | Raster lines per glyph line, minus one |
| ramWe | input | 1 | Video RAM write strobe |
| ramAddr | input | 8 | Video RAM address: row and offset |
| ramData | input | 7 | Character code or attribute to write |
| red | output | 1 | Red video |
| green | output | 1 | Green video |
| blue | output | 1 | Blue video |
| blank | output | 1 | Overlay enable for the mixer |

## Verification
A horizontal sync and a vertical sync can land on the same clock edge. Every frame the bench drives starts this way, and the line drawn after it must show glyph line 0 and not line 1; with a pixel height of one line the two differ visibly. A vertical sync on its own is also sent partway through a line. Pixels after it must show line 0 content while their horizontal position keeps its count, which shows that the pixel counter was not restarted. Every pixel of every line is compared with a model computed from the requirements.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int unsigned ROWS     = 6;
  localparam int unsigned COLS     = 20;
  localparam int unsigned CELL_W   = 12;
  localparam int unsigned CELL_H   = 15;
  localparam int unsigned WORD_W   = 6;
  localparam int unsigned CODE_W   = 7;
  localparam int unsigned GLYPHS   = 96;
  localparam int unsigned HCNT_W   = 10;
  localparam int unsigned VCNT_W   = 10;
  localparam int unsigned POS_W    = 8;
  localparam int unsigned RAM_AW   = 8;
  localparam int unsigned OFF_W    = 5;

  localparam int unsigned ROW_W    = $clog2(ROWS);
  localparam int unsigned COL_W    = $clog2(COLS);
  localparam int unsigned PIX_W    = $clog2(CELL_W);
  localparam int unsigned GL_W     = $clog2(CELL_H);
  localparam int unsigned HALVES   = CELL_W / WORD_W;
  localparam int unsigned WPG      = CELL_H * HALVES;
  localparam int unsigned ROM_DEPTH = GLYPHS * WPG;
  localparam int unsigned ROM_AW   = $clog2(ROM_DEPTH);
  localparam int unsigned CELLS    = ROWS * COLS;
  localparam int unsigned IDX_W    = $clog2(CELLS);
  localparam int unsigned SEL_W    = $clog2(WORD_W);

  typedef struct packed {
    logic             draw;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [GL_W-1:0]  gLine;
    logic [PIX_W-1:0] pix;
  } osdPos_t;
endpackage

// File: rtl/osd_glyph_rom.sv
module osd_glyph_rom
  import osd_pkg::*;
(
  input  logic [ROM_AW-1:0] addr,
  output logic [WORD_W-1:0] word
);
  // Test content: low address bits folded with the high ones
  always_comb begin
    if (int'(addr) < ROM_DEPTH)
      word = addr[WORD_W-1:0] ^ WORD_W'(addr >> WORD_W);
    else
      word = '0;
  end
endmodule

// File: rtl/osd_ctrl.sv
module osd_ctrl
  import osd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hSync,
  input  logic             vSync,
  input  logic [POS_W-1:0] vertPos,
  input  logic [POS_W-1:0] horzPos,
  input  logic [1:0]       pixSize,
  output osdPos_t          pos
);
  logic [HCNT_W-1:0] hCnt;
  logic [VCNT_W-1:0] vCnt;
  logic hAct, vAct;
  logic [PIX_W-1:0] pixIdx;
  logic [COL_W-1:0] colIdx;
  logic [1:0]       subLn;
  logic [GL_W-1:0]  gLine;
  logic [ROW_W-1:0] rowIdx;

  logic hStart, vStart, lastPix, lastCol, lastSub, lastGl, lastRow;

  assign hStart  = (hCnt != '1) && ((hCnt + HCNT_W'(1)) == HCNT_W'(horzPos));
  assign vStart  = (vCnt != '1) && ((vCnt + VCNT_W'(1)) == VCNT_W'(vertPos));
  assign lastPix = pixIdx == PIX_W'(CELL_W - 1);
  assign lastCol = colIdx == COL_W'(COLS - 1);
  assign lastSub = subLn >= pixSize;
  assign lastGl  = gLine == GL_W'(CELL_H - 1);
  assign lastRow = rowIdx == ROW_W'(ROWS - 1);

  // Raster counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      if (hSync) hCnt <= '0;
      else if (hCnt != '1) hCnt <= hCnt + HCNT_W'(1);
      if (vSync) vCnt <= '0;
      else if (hSync && vCnt != '1) vCnt <= vCnt + VCNT_W'(1);
    end
  end

  // Horizontal cell walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hAct   <= 1'b0;
      pixIdx <= '0;
      colIdx <= '0;
    end else if (hSync) begin
      hAct   <= (horzPos == '0);
      pixIdx <= '0;
      colIdx <= '0;
    end else if (hAct) begin
      if (lastPix) begin
        pixIdx <= '0;
        if (lastCol) hAct <= 1'b0;
        else colIdx <= colIdx + COL_W'(1);
      end else begin
        pixIdx <= pixIdx + PIX_W'(1);
      end
    end else if (hStart) begin
      hAct   <= 1'b1;
      pixIdx <= '0;
      colIdx <= '0;
    end
  end

  // Vertical row walk, one step per line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vAct   <= 1'b0;
      subLn  <= '0;
      gLine  <= '0;
      rowIdx <= '0;
    end else if (vSync) begin
      vAct   <= (vertPos == '0);
      subLn  <= '0;
      gLine  <= '0;
      rowIdx <= '0;
    end else if (hSync) begin
      if (vAct) begin
        if (lastSub) begin
          subLn <= '0;
          if (lastGl) begin
            gLine <= '0;
            if (lastRow) vAct <= 1'b0;
            else rowIdx <= rowIdx + ROW_W'(1);
          end else begin
            gLine <= gLine + GL_W'(1);
          end
        end else begin
          subLn <= subLn + 2'd1;
        end
      end else if (vStart) begin
        vAct   <= 1'b1;
        subLn  <= '0;
        gLine  <= '0;
        rowIdx <= '0;
      end
    end
  end

  always_comb begin
    pos.draw  = hAct & vAct;
    pos.row   = rowIdx;
    pos.col   = colIdx;
    pos.gLine = gLine;
    pos.pix   = pixIdx;
  end

  p_hcnt_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    hSync |=> hCnt == '0);
  p_line_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    vSync |=> vCnt == '0);
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hSync && !vSync && vCnt != '1) |=> vCnt == $past(vCnt) + VCNT_W'(1));
  p_cell_bounds_r4: assert property (@(posedge clk) disable iff (!rstN)
    pos.draw |-> (colIdx < COL_W'(COLS) && pixIdx < PIX_W'(CELL_W)
                  && gLine < GL_W'(CELL_H) && rowIdx < ROW_W'(ROWS)));
  p_window_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hAct && lastPix && lastCol && !hSync) |=> !hAct);
  p_gline_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hSync && !vSync && vAct && subLn < pixSize) |=> gLine == $past(gLine));
endmodule

// File: rtl/osd_dpath.sv
module osd_dpath
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramWe,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic [CODE_W-1:0] ramData,
  input  osdPos_t           pos,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [WORD_W-1:0] romWord,
  output logic              red,
  output logic              green,
  output logic              blue,
  output logic              blank
);
  logic [CODE_W-1:0] charMem [CELLS];
  logic [CODE_W-1:0] attrMem [ROWS];

  logic [ROW_W-1:0] wrRow;
  logic [OFF_W-1:0] wrOff;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CODE_W-1:0] code, attr;
  logic half, codeOk, fgBit, bgEn;
  logic [PIX_W-1:0] bitPos;
  logic [SEL_W-1:0] selIdx;

  assign wrRow = ROW_W'(ramAddr >> OFF_W);
  assign wrOff = ramAddr[OFF_W-1:0];
  assign wrIdx = IDX_W'(wrRow) * IDX_W'(COLS) + IDX_W'(wrOff) - IDX_W'(1);

  always_ff @(posedge clk) begin
    if (ramWe && wrRow < ROW_W'(ROWS)) begin
      if (wrOff == '0)
        attrMem[wrRow] <= ramData;
      else if (wrOff <= OFF_W'(COLS))
        charMem[wrIdx] <= ramData;
    end
  end

  // Fetch: cell code, row attribute, glyph word, pixel bit
  assign rdIdx   = IDX_W'(pos.row) * IDX_W'(COLS) + IDX_W'(pos.col);
  assign code    = charMem[rdIdx];
  assign attr    = attrMem[pos.row];
  assign half    = pos.pix >= PIX_W'(WORD_W);
  assign bitPos  = half ? pos.pix - PIX_W'(WORD_W) : pos.pix;
  assign selIdx  = SEL_W'(WORD_W - 1) - SEL_W'(bitPos);
  assign romAddr = ROM_AW'(code) * ROM_AW'(WPG) + ROM_AW'(pos.gLine) * ROM_AW'(HALVES)
                 + ROM_AW'(half);
  assign codeOk  = code < CODE_W'(GLYPHS);
  assign fgBit   = pos.draw && codeOk && romWord[selIdx];
  assign bgEn    = attr[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {red, green, blue} <= 3'b000;
      blank <= 1'b0;
    end else if (fgBit) begin
      {red, green, blue} <= attr[2:0];
      blank <= 1'b1;
    end else if (pos.draw && bgEn) begin
      {red, green, blue} <= attr[6:4];
      blank <= 1'b1;
    end else begin
      {red, green, blue} <= 3'b000;
      blank <= 1'b0;
    end
  end

  p_dark_outside_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pos.draw |=> ({red, green, blue} == 3'b000 && !blank));
  p_blank_covers_r11: assert property (@(posedge clk) disable iff (!rstN)
    !blank |-> {red, green, blue} == 3'b000);
  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pos.draw && !codeOk && !bgEn) |=> !blank);
endmodule

// File: rtl/osd_gen.sv
module osd_gen
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSync,
  input  logic              vSync,
  input  logic [POS_W-1:0]  vertPos,
  input  logic [POS_W-1:0]  horzPos,
  input  logic [1:0]        pixSize,
  input  logic              ramWe,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic [CODE_W-1:0] ramData,
  output logic              red,
  output logic              green,
  output logic              blue,
  output logic              blank
);
  osdPos_t           pos;
  logic [ROM_AW-1:0] romAddr;
  logic [WORD_W-1:0] romWord;

  osd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync),
    .vertPos(vertPos), .horzPos(horzPos), .pixSize(pixSize), .pos(pos)
  );

  osd_glyph_rom i_rom (.addr(romAddr), .word(romWord));

  osd_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .pos(pos), .romAddr(romAddr), .romWord(romWord),
    .red(red), .green(green), .blue(blue), .blank(blank)
  );
endmodule

// File: tb/test_osd_gen.sv
`timescale 1ns/1ps
module test_osd_gen;
  localparam int LINE = 260;
  // {vertPos, horzPos, pixSize, lines}
  localparam int CFG [4][4] = '{'{3, 5, 0, 96}, '{0, 0, 1, 182},
                                '{1, 16, 3, 64}, '{5, 1, 2, 70}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSync = 1'b0, vSync = 1'b0, ramWe = 1'b0;
  logic [7:0] vertPos = '0, horzPos = '0, ramAddr = '0;
  logic [1:0] pixSize = '0;
  logic [6:0] ramData = '0;
  logic red, green, blue, blank;

  int checks = 0, fails = 0;
  bit done = 0;
  int bChar [120];
  int bAttr [6];
  int curVp, curHp, curSz;

  always #2 clk = ~clk;

  osd_gen i_osd_gen (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .vertPos(vertPos),
    .horzPos(horzPos), .pixSize(pixSize), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .red(red), .green(green), .blue(blue), .blank(blank)
  );

  function automatic int expPix(int v, int k, output string tag);
    int x, dy, lh, row, gl, col, px, hf, bt, code, attr, a, w;
    x = k - curHp - 1;
    tag = "R2";
    if (x < 0 || x >= 240) return 0;
    lh = curSz + 1;
    dy = v - curVp;
    tag = (curSz != 0) ? "R5" : "R3";
    if (dy < 0 || dy >= 90 * lh) return 0;
    row = dy / (15 * lh);
    gl = (dy % (15 * lh)) / lh;
    col = x / 12;
    px = x % 12;
    hf = px / 6;
    bt = 5 - (px % 6);
    code = bChar[row * 20 + col];
    attr = bAttr[row];
    if (code < 96) begin
      a = code * 30 + gl * 2 + hf;
      w = (a % 64) ^ (a / 64);
      if (((w >> bt) & 1) == 1) begin
        tag = "R7";
        return 8 | (attr & 7);
      end
    end else tag = "R8";
    if (((attr >> 3) & 1) == 1) begin
      if (tag != "R8") tag = "R9";
      return 8 | ((attr >> 4) & 7);
    end
    if (tag != "R8") tag = "R11";
    return 0;
  endfunction

  task automatic checkPix(int v, int k);
    string tag;
    int e, got;
    e = expPix(v, k, tag);
    got = {28'd0, blank, red, green, blue};
    checks++;
    if (got != e) begin
      fails++;
      $display("FAIL %s R10 line %0d cnt %0d got %h exp %h", tag, v, k, got, e);
    end
  endtask

  // Called at a negedge; leaves at a negedge with the count at LINE-1
  task automatic runLine(bit withV, int vIdx, int vsAt);
    hSync = 1'b1;
    vSync = withV;
    @(negedge clk);
    hSync = 1'b0;
    for (int k = 0; k < LINE; k++) begin
      if (k > 0) @(negedge clk);
      vSync = 1'b0;
      checkPix((vsAt >= 0 && k > vsAt + 1) ? 0 : vIdx, k);
      if (k == vsAt) vSync = 1'b1;
    end
  endtask

  task automatic ramWrite(int addr, int data);
    ramWe = 1'b1;
    ramAddr = 8'(addr);
    ramData = 7'(data);
    @(negedge clk);
    ramWe = 1'b0;
  endtask

  task automatic setCfg(int vp, int hp, int sz);
    curVp = vp; curHp = hp; curSz = sz;
    vertPos = 8'(vp); horzPos = 8'(hp); pixSize = 2'(sz);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({blank, red, green, blue} != 4'b0) begin
      fails++;
      $display("FAIL R1 during reset got %b exp 0000", {blank, red, green, blue});
    end
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if ({blank, red, green, blue} != 4'b0) begin
      fails++;
      $display("FAIL R1 after reset got %b exp 0000", {blank, red, green, blue});
    end

    // R6: load every cell and row attribute through the row/offset map
    for (int r = 0; r < 6; r++) begin
      bAttr[r] = (r * 37 + 5) % 128;
      ramWrite(r * 32, bAttr[r]);
      for (int c = 0; c < 20; c++) begin
        bChar[r * 20 + c] = ((r * 20 + c) * 7 + 3) % 128;
        ramWrite(r * 32 + 1 + c, bChar[r * 20 + c]);
      end
    end
    // R6: writes to offset 21 and row 6 must be ignored
    ramWrite(21, 127);
    ramWrite(6 * 32 + 1, 127);
    ramWrite(7 * 32, 127);

    // Table of frame configurations (R2 R3 R4 R5 R7 R8 R9 R10 R11)
    for (int i = 0; i < 4; i++) begin
      setCfg(CFG[i][0], CFG[i][1], CFG[i][2]);
      for (int v = 0; v < CFG[i][3]; v++) runLine(v == 0, v, -1);
    end

    // R3: vertical sync alone mid-line restarts lines, not pixels
    setCfg(0, 0, 0);
    for (int v = 0; v < 6; v++) runLine(v == 0, v, -1);
    runLine(1'b0, 6, 100);
    runLine(1'b0, 1, -1);
    runLine(1'b0, 2, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule